// File: doc/BRIEF.md
# Ownership-Tracking Snoop Coherence Controller

This block keeps a small direct-mapped write-back cache coherent with its peers on a shared snooping bus. Each line carries a tag, one data word and one of four coherence states. The protocol replaces the usual dirty bit with ownership: the cache that owns a line is the one that must eventually write it back. A line that is shared but not owned is treated as disposable and is discarded silently, even when its contents differ from memory.

The processor side issues reads and writes. Hits complete one cycle later. Misses post a bus request and wait for the fill data, and an owned victim is written back in the same cycle the miss is posted. The snoop side watches the bus. It gives up or downgrades lines when other caches request them. When it holds an owned copy, it supplies the data itself and raises a flag that keeps memory from answering. An optional read-broadcast mode lets a line that was invalidated here pick up data that is flowing past on the bus for another requester.

Top module: `own_coh_ctrl`

## Requirements
- R1: After reset every line is invalid, `cpu_ready` is 1, and `cpu_done`, `bus_valid`, `wb_valid` and `snp_supply` are 0.
- R2: A processor read that misses drives `bus_valid` with `bus_cmd`=01 (read) and the request address in the cycle after the request, and drops `cpu_ready` until fill. When `fill_valid` arrives, `cpu_done` returns the fill word in the next cycle and the line becomes unowned-shared.
- R3: A processor read that hits raises `cpu_done` with the stored word in the cycle after the request, with no bus command.
- R4: A processor write that hits an unowned-shared or owned-shared line emits `bus_cmd`=11 (invalidate) with the line address, together with `cpu_done`. The line becomes owned-exclusive. On writes `cpu_rdata` returns the written word.
- R5: A processor write that hits an owned-exclusive line completes in one cycle with no bus command.
- R6: A processor write that misses emits `bus_cmd`=10 (read-exclusive). The fill is discarded in favour of the written word, and the line becomes owned-exclusive.
- R7: A snooped read (`snp_cmd`=01) that hits an owned line raises `snp_supply` with the line's word in `snp_sdata` in the next cycle. An owned-exclusive line moves to owned-shared, so a later local write broadcasts an invalidate.
- R8: A snooped read that hits an unowned-shared line leaves it valid and does not raise `snp_supply`.
- R9: A snooped invalidate (11) or read-exclusive (10) that hits a valid line makes it invalid, so a later local access misses. A read-exclusive that hits an owned line also supplies the word.
- R10: On a miss whose victim is owned, `wb_valid` is raised with the victim's address and word in the same cycle as the bus request. An unowned-shared victim is dropped with no write-back.
- R11: With `rd_bcast_en`=1, bus data (`snp_dvalid`) whose address tag matches an invalid line here installs that line as unowned-shared with that word. With `rd_bcast_en`=0, or when the tag differs, nothing is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_bcast_en | input | 1 | Enables capture of passing read data into invalid lines |
| cpu_req | input | 1 | Processor request strobe, accepted when `cpu_ready` is 1 |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_wdata | input | DATA_W | Processor write word |
| cpu_ready | output | 1 | No miss outstanding |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read word, or the written word on writes |
| bus_valid | output | 1 | One-cycle bus request pulse |
| bus_cmd | output | 2 | 01 read, 10 read-exclusive, 11 invalidate |
| bus_addr | output | ADDR_W | Bus request address |
| fill_valid | input | 1 | Fill data for the outstanding miss |
| fill_data | input | DATA_W | Fill word |
| snp_valid | input | 1 | Snooped command from another cache |
| snp_cmd | input | 2 | Snooped command code, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| snp_dvalid | input | 1 | Read data passing on the bus |
| snp_data | input | DATA_W | Passing read word |
| snp_supply | output | 1 | This cache answers the snooped read; memory must stay silent |
| snp_sdata | output | DATA_W | Word supplied to the requester |
| wb_valid | output | 1 | Write-back pulse to memory |
| wb_addr | output | ADDR_W | Write-back address |
| wb_data | output | DATA_W | Write-back word |

## Verification
The assertions assume that a snooped command never names the same line index as a processor access or fill in the same cycle. They also assume that `snp_valid` and `snp_dvalid` are never high together, and that `fill_valid` comes only while a miss is outstanding. The bench respects all of this by construction: every processor access, fill, snoop command and data phase is driven in cycles of its own. Fills are issued only after the bench has seen the corresponding bus request. Processor requests are strobed for exactly one cycle, and only when `cpu_ready` is high.

// File: rtl/own_coh_pkg.sv
package own_coh_pkg;

    typedef enum logic [1:0] {
        LS_INV = 2'b00,
        LS_USH = 2'b01,
        LS_OSH = 2'b10,
        LS_OEX = 2'b11
    } line_st_e;

    typedef enum logic [1:0] {
        BC_NONE = 2'b00,
        BC_READ = 2'b01,
        BC_RDEX = 2'b10,
        BC_KILL = 2'b11
    } bus_cmd_e;

    function automatic logic is_owned(logic [1:0] s);
        return (s == LS_OSH) || (s == LS_OEX);
    endfunction

endpackage

// File: rtl/own_coh_store.sv
module own_coh_store #(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    // lookup port for the processor side
    input  logic [IDX_W-1:0]  ra_idx,
    output logic [1:0]        ra_st,
    output logic [TAG_W-1:0]  ra_tag,
    output logic [DATA_W-1:0] ra_data,
    // lookup port for the snoop side
    input  logic [IDX_W-1:0]  rb_idx,
    output logic [1:0]        rb_st,
    output logic [TAG_W-1:0]  rb_tag,
    output logic [DATA_W-1:0] rb_data,
    // processor-side update (wins on the same index)
    input  logic              cw_en,
    input  logic [IDX_W-1:0]  cw_idx,
    input  logic [1:0]        cw_st,
    input  logic [TAG_W-1:0]  cw_tag,
    input  logic [DATA_W-1:0] cw_data,
    // snoop-side update (tag untouched)
    input  logic              sw_en,
    input  logic [IDX_W-1:0]  sw_idx,
    input  logic [1:0]        sw_st,
    input  logic              sw_data_en,
    input  logic [DATA_W-1:0] sw_data
);
    localparam int LINES = 1 << IDX_W;

    typedef struct packed {
        logic [1:0]        st;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } entry_t;

    entry_t ent_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        entry_t line_d;
        entry_t line_q;

        always_comb begin
            line_d = line_q;
            if (cw_en && (cw_idx == IDX_W'(g))) begin
                line_d.st   = cw_st;
                line_d.tag  = cw_tag;
                line_d.data = cw_data;
            end else if (sw_en && (sw_idx == IDX_W'(g))) begin
                line_d.st = sw_st;
                if (sw_data_en) begin
                    line_d.data = sw_data;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                line_q <= '0;
            end else begin
                line_q <= line_d;
            end
        end

        assign ent_q[g] = line_q;
    end

    assign ra_st   = ent_q[ra_idx].st;
    assign ra_tag  = ent_q[ra_idx].tag;
    assign ra_data = ent_q[ra_idx].data;
    assign rb_st   = ent_q[rb_idx].st;
    assign rb_tag  = ent_q[rb_idx].tag;
    assign rb_data = ent_q[rb_idx].data;

endmodule

// File: rtl/own_coh_snoop.sv
module own_coh_snoop
    import own_coh_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd_bcast_en,
    input  logic                    snp_valid,
    input  logic [1:0]              snp_cmd,
    input  logic [ADDR_W-1:0]       snp_addr,
    input  logic                    snp_dvalid,
    input  logic [DATA_W-1:0]       snp_data,
    input  logic                    pend_busy,
    input  logic [IDX_W-1:0]        pend_idx,
    input  logic [1:0]              line_st,
    input  logic [ADDR_W-IDX_W-1:0] line_tag,
    input  logic [DATA_W-1:0]       line_data,
    output logic                    sw_en,
    output logic [IDX_W-1:0]        sw_idx,
    output logic [1:0]              sw_st,
    output logic                    sw_data_en,
    output logic [DATA_W-1:0]       sw_data,
    output logic                    supply_o,
    output logic [DATA_W-1:0]       sdata_o
);
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        logic              supply;
        logic [DATA_W-1:0] sdata;
    } resp_t;

    resp_t r_d, r_q;

    logic [TAG_W-1:0] s_tag;
    logic             tag_hit;
    logic             line_valid;
    logic             blocked;

    assign s_tag      = snp_addr[ADDR_W-1:IDX_W];
    assign tag_hit    = (line_tag == s_tag);
    assign line_valid = (line_st != LS_INV);
    assign blocked    = pend_busy && (pend_idx == snp_addr[IDX_W-1:0]);
    assign sw_idx     = snp_addr[IDX_W-1:0];

    always_comb begin
        r_d        = r_q;
        r_d.supply = 1'b0;
        sw_en      = 1'b0;
        sw_st      = line_st;
        sw_data_en = 1'b0;
        sw_data    = snp_data;

        if (snp_valid && tag_hit && line_valid) begin
            unique case (snp_cmd)
                BC_READ: begin
                    if (is_owned(line_st)) begin
                        r_d.supply = 1'b1;
                        r_d.sdata  = line_data;
                    end
                    if (line_st == LS_OEX) begin
                        sw_en = 1'b1;
                        sw_st = LS_OSH;
                    end
                end
                BC_RDEX: begin
                    if (is_owned(line_st)) begin
                        r_d.supply = 1'b1;
                        r_d.sdata  = line_data;
                    end
                    sw_en = 1'b1;
                    sw_st = LS_INV;
                end
                BC_KILL: begin
                    sw_en = 1'b1;
                    sw_st = LS_INV;
                end
                default: ;
            endcase
        end else if (!snp_valid && snp_dvalid && rd_bcast_en && tag_hit
                     && !line_valid && !blocked) begin
            sw_en      = 1'b1;
            sw_st      = LS_USH;
            sw_data_en = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign supply_o = r_q.supply;
    assign sdata_o  = r_q.sdata;

endmodule

// File: rtl/own_coh_cpu.sv
module own_coh_cpu
    import own_coh_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_req,
    input  logic                    cpu_we,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [DATA_W-1:0]       cpu_wdata,
    input  logic                    fill_valid,
    input  logic [DATA_W-1:0]       fill_data,
    input  logic [1:0]              line_st,
    input  logic [ADDR_W-IDX_W-1:0] line_tag,
    input  logic [DATA_W-1:0]       line_data,
    output logic                    cw_en,
    output logic [IDX_W-1:0]        cw_idx,
    output logic [1:0]              cw_st,
    output logic [ADDR_W-IDX_W-1:0] cw_tag,
    output logic [DATA_W-1:0]       cw_data,
    output logic                    pend_busy,
    output logic [IDX_W-1:0]        pend_idx,
    output logic                    cpu_ready,
    output logic                    cpu_done,
    output logic [DATA_W-1:0]       cpu_rdata,
    output logic                    bus_valid,
    output logic [1:0]              bus_cmd,
    output logic [ADDR_W-1:0]       bus_addr,
    output logic                    wb_valid,
    output logic [ADDR_W-1:0]       wb_addr,
    output logic [DATA_W-1:0]       wb_data
);
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        logic              busy;
        logic [ADDR_W-1:0] paddr;
        logic              pwe;
        logic [DATA_W-1:0] pwdata;
        logic              done;
        logic [DATA_W-1:0] rdata;
        logic              bv;
        logic [1:0]        bcmd;
        logic [ADDR_W-1:0] baddr;
        logic              wbv;
        logic [ADDR_W-1:0] wbaddr;
        logic [DATA_W-1:0] wbdata;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [TAG_W-1:0] req_tag;
    logic [IDX_W-1:0] req_idx;
    logic             hit;

    assign req_tag = cpu_addr[ADDR_W-1:IDX_W];
    assign req_idx = cpu_addr[IDX_W-1:0];
    assign hit     = (line_st != LS_INV) && (line_tag == req_tag);

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        c_d.bv   = 1'b0;
        c_d.wbv  = 1'b0;
        cw_en    = 1'b0;
        cw_idx   = req_idx;
        cw_st    = line_st;
        cw_tag   = req_tag;
        cw_data  = line_data;

        if (!c_q.busy) begin
            if (cpu_req) begin
                if (hit) begin
                    c_d.done = 1'b1;
                    if (!cpu_we) begin
                        c_d.rdata = line_data;
                    end else begin
                        c_d.rdata = cpu_wdata;
                        cw_en     = 1'b1;
                        cw_st     = LS_OEX;
                        cw_data   = cpu_wdata;
                        if (line_st != LS_OEX) begin
                            c_d.bv    = 1'b1;
                            c_d.bcmd  = BC_KILL;
                            c_d.baddr = cpu_addr;
                        end
                    end
                end else begin
                    if (is_owned(line_st)) begin
                        c_d.wbv    = 1'b1;
                        c_d.wbaddr = {line_tag, req_idx};
                        c_d.wbdata = line_data;
                    end
                    cw_en      = 1'b1;
                    cw_st      = LS_INV;
                    c_d.bv     = 1'b1;
                    c_d.bcmd   = cpu_we ? BC_RDEX : BC_READ;
                    c_d.baddr  = cpu_addr;
                    c_d.busy   = 1'b1;
                    c_d.paddr  = cpu_addr;
                    c_d.pwe    = cpu_we;
                    c_d.pwdata = cpu_wdata;
                end
            end
        end else if (fill_valid) begin
            cw_en     = 1'b1;
            cw_idx    = c_q.paddr[IDX_W-1:0];
            cw_tag    = c_q.paddr[ADDR_W-1:IDX_W];
            cw_st     = c_q.pwe ? LS_OEX : LS_USH;
            cw_data   = c_q.pwe ? c_q.pwdata : fill_data;
            c_d.rdata = c_q.pwe ? c_q.pwdata : fill_data;
            c_d.done  = 1'b1;
            c_d.busy  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign pend_busy = c_q.busy;
    assign pend_idx  = c_q.paddr[IDX_W-1:0];
    assign cpu_ready = !c_q.busy;
    assign cpu_done  = c_q.done;
    assign cpu_rdata = c_q.rdata;
    assign bus_valid = c_q.bv;
    assign bus_cmd   = c_q.bcmd;
    assign bus_addr  = c_q.baddr;
    assign wb_valid  = c_q.wbv;
    assign wb_addr   = c_q.wbaddr;
    assign wb_data   = c_q.wbdata;

endmodule

// File: rtl/own_coh_ctrl.sv
module own_coh_ctrl #(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_bcast_en,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_valid,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              snp_dvalid,
    input  logic [DATA_W-1:0] snp_data,
    output logic              snp_supply,
    output logic [DATA_W-1:0] snp_sdata,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [1:0]        a_st,   b_st;
    logic [TAG_W-1:0]  a_tag,  b_tag;
    logic [DATA_W-1:0] a_data, b_data;

    logic              cw_en;
    logic [IDX_W-1:0]  cw_idx;
    logic [1:0]        cw_st;
    logic [TAG_W-1:0]  cw_tag;
    logic [DATA_W-1:0] cw_data;

    logic              sw_en;
    logic [IDX_W-1:0]  sw_idx;
    logic [1:0]        sw_st;
    logic              sw_data_en;
    logic [DATA_W-1:0] sw_data;

    logic              pend_busy;
    logic [IDX_W-1:0]  pend_idx;

    own_coh_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .ra_idx     (cpu_addr[IDX_W-1:0]),
        .ra_st      (a_st),
        .ra_tag     (a_tag),
        .ra_data    (a_data),
        .rb_idx     (snp_addr[IDX_W-1:0]),
        .rb_st      (b_st),
        .rb_tag     (b_tag),
        .rb_data    (b_data),
        .cw_en      (cw_en),
        .cw_idx     (cw_idx),
        .cw_st      (cw_st),
        .cw_tag     (cw_tag),
        .cw_data    (cw_data),
        .sw_en      (sw_en),
        .sw_idx     (sw_idx),
        .sw_st      (sw_st),
        .sw_data_en (sw_data_en),
        .sw_data    (sw_data)
    );

    own_coh_cpu #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_cpu (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .fill_valid (fill_valid),
        .fill_data  (fill_data),
        .line_st    (a_st),
        .line_tag   (a_tag),
        .line_data  (a_data),
        .cw_en      (cw_en),
        .cw_idx     (cw_idx),
        .cw_st      (cw_st),
        .cw_tag     (cw_tag),
        .cw_data    (cw_data),
        .pend_busy  (pend_busy),
        .pend_idx   (pend_idx),
        .cpu_ready  (cpu_ready),
        .cpu_done   (cpu_done),
        .cpu_rdata  (cpu_rdata),
        .bus_valid  (bus_valid),
        .bus_cmd    (bus_cmd),
        .bus_addr   (bus_addr),
        .wb_valid   (wb_valid),
        .wb_addr    (wb_addr),
        .wb_data    (wb_data)
    );

    own_coh_snoop #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_snoop (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_bcast_en (rd_bcast_en),
        .snp_valid   (snp_valid),
        .snp_cmd     (snp_cmd),
        .snp_addr    (snp_addr),
        .snp_dvalid  (snp_dvalid),
        .snp_data    (snp_data),
        .pend_busy   (pend_busy),
        .pend_idx    (pend_idx),
        .line_st     (b_st),
        .line_tag    (b_tag),
        .line_data   (b_data),
        .sw_en       (sw_en),
        .sw_idx      (sw_idx),
        .sw_st       (sw_st),
        .sw_data_en  (sw_data_en),
        .sw_data     (sw_data),
        .supply_o    (snp_supply),
        .sdata_o     (snp_sdata)
    );

endmodule

// File: rtl/own_coh_chk.sv
module own_coh_chk #(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_ready,
    input logic              cpu_we,
    input logic              cpu_done,
    input logic              bus_valid,
    input logic [1:0]        bus_cmd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              fill_valid,
    input logic              snp_valid,
    input logic [1:0]        snp_cmd,
    input logic              snp_supply,
    input logic              wb_valid,
    input logic [ADDR_W-1:0] wb_addr
);
    // R2: a posted miss request leaves the processor port stalled
    p_miss_stalls_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && (bus_cmd == 2'b01 || bus_cmd == 2'b10) |-> !cpu_ready);

    // R6: a fill for the outstanding miss completes in the next cycle
    p_fill_completes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid && !cpu_ready |=> cpu_done);

    // R3: a completion never coincides with a fresh miss request
    p_done_no_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> !(bus_valid && (bus_cmd == 2'b01 || bus_cmd == 2'b10)));

    // R4: an invalidate broadcast only accompanies a completed write
    p_inval_from_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_cmd == 2'b11 |-> cpu_done && $past(cpu_we));

    // R7: supply only follows a snooped read or read-exclusive
    p_supply_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply |-> $past(snp_valid) && ($past(snp_cmd) == 2'b01 || $past(snp_cmd) == 2'b10));

    // R10: a write-back rides with a miss request to a different tag, same index
    p_wb_with_miss_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> bus_valid && (bus_cmd == 2'b01 || bus_cmd == 2'b10)
                     && (wb_addr[IDX_W-1:0] == bus_addr[IDX_W-1:0]) && (wb_addr != bus_addr));

endmodule

bind own_coh_ctrl own_coh_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_ready  (cpu_ready),
    .cpu_we     (cpu_we),
    .cpu_done   (cpu_done),
    .bus_valid  (bus_valid),
    .bus_cmd    (bus_cmd),
    .bus_addr   (bus_addr),
    .fill_valid (fill_valid),
    .snp_valid  (snp_valid),
    .snp_cmd    (snp_cmd),
    .snp_supply (snp_supply),
    .wb_valid   (wb_valid),
    .wb_addr    (wb_addr)
);

// File: tb/own_coh_ctrl_tb.sv
module own_coh_ctrl_tb;
    localparam int AW = 12;
    localparam int DW = 16;
    localparam logic [1:0] C_RD = 2'b01, C_RX = 2'b10, C_KL = 2'b11;
    localparam logic [AW-1:0] A_ADR = 12'h010, B_ADR = 12'h020, C_ADR = 12'h011;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_bcast_en = 1'b0;
    logic cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic cpu_ready, cpu_done, bus_valid, snp_supply, wb_valid;
    logic [DW-1:0] cpu_rdata, snp_sdata, wb_data;
    logic [1:0] bus_cmd;
    logic [AW-1:0] bus_addr, wb_addr;
    logic fill_valid = 1'b0;
    logic [DW-1:0] fill_data = '0;
    logic snp_valid = 1'b0, snp_dvalid = 1'b0;
    logic [1:0] snp_cmd = 2'b00;
    logic [AW-1:0] snp_addr = '0;
    logic [DW-1:0] snp_data = '0;

    always #10 clk = ~clk;

    own_coh_ctrl #(.ADDR_W(AW), .IDX_W(2), .DATA_W(DW)) u_dut (.*);

    int n_chk = 0, n_fail = 0;
    int n_bus = 0, n_wb = 0, n_sup = 0;
    string cur_req = "R1";

    logic [DW-1:0]   q_cpu[$]; string t_cpu[$];
    logic [AW+1:0]   q_bus[$]; string t_bus[$];
    logic [AW+DW-1:0] q_wb[$]; string t_wb[$];
    logic [DW-1:0]   q_sup[$]; string t_sup[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: pops scoreboard items as outputs pulse
    always @(negedge clk) begin
        if (rst_n) begin
            if (cpu_done) begin
                if (q_cpu.size() == 0) chk(0, cur_req, "unexpected cpu_done", 32'(cpu_rdata), 0);
                else begin
                    logic [DW-1:0] e; string t;
                    e = q_cpu.pop_front(); t = t_cpu.pop_front();
                    chk(cpu_rdata == e, t, "cpu_rdata", 32'(cpu_rdata), 32'(e));
                end
            end
            if (bus_valid) begin
                n_bus++;
                if (q_bus.size() == 0) chk(0, cur_req, "unexpected bus request", 32'({bus_cmd, bus_addr}), 0);
                else begin
                    logic [AW+1:0] e; string t;
                    e = q_bus.pop_front(); t = t_bus.pop_front();
                    chk({bus_cmd, bus_addr} == e, t, "bus {cmd,addr}", 32'({bus_cmd, bus_addr}), 32'(e));
                end
            end
            if (wb_valid) begin
                n_wb++;
                if (q_wb.size() == 0) chk(0, cur_req, "unexpected write-back", 32'({wb_addr, wb_data}), 0);
                else begin
                    logic [AW+DW-1:0] e; string t;
                    e = q_wb.pop_front(); t = t_wb.pop_front();
                    chk({wb_addr, wb_data} == e, t, "write-back {addr,data}", 32'({wb_addr, wb_data}), 32'(e));
                end
            end
            if (snp_supply) begin
                n_sup++;
                if (q_sup.size() == 0) chk(0, cur_req, "unexpected supply", 32'(snp_sdata), 0);
                else begin
                    logic [DW-1:0] e; string t;
                    e = q_sup.pop_front(); t = t_sup.pop_front();
                    chk(snp_sdata == e, t, "snp_sdata", 32'(snp_sdata), 32'(e));
                end
            end
        end
    end

    task automatic exp_cpu(input logic [DW-1:0] d, input string r); q_cpu.push_back(d); t_cpu.push_back(r); endtask
    task automatic exp_bus(input logic [1:0] c, input logic [AW-1:0] a, input string r); q_bus.push_back({c, a}); t_bus.push_back(r); endtask
    task automatic exp_wb(input logic [AW-1:0] a, input logic [DW-1:0] d, input string r); q_wb.push_back({a, d}); t_wb.push_back(r); endtask
    task automatic exp_sup(input logic [DW-1:0] d, input string r); q_sup.push_back(d); t_sup.push_back(r); endtask

    task automatic access(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_req = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic fill(input logic [DW-1:0] d);
        @(negedge clk);
        fill_valid = 1'b1; fill_data = d;
        @(negedge clk);
        fill_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
        @(negedge clk);
        snp_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic snoop_data(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        snp_dvalid = 1'b1; snp_addr = a; snp_data = d;
        @(negedge clk);
        snp_dvalid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic drained(input string r);
        int left;
        left = q_cpu.size() + q_bus.size() + q_wb.size() + q_sup.size();
        chk(left == 0, r, "pending expected events", 32'(left), 0);
    endtask

    task automatic rd_miss(input logic [AW-1:0] a, input logic [DW-1:0] d, input string r);
        exp_bus(C_RD, a, r);
        exp_cpu(d, r);
        access(1'b0, a, '0);
        chk(cpu_ready == 1'b0, r, "cpu_ready while fill pending", 32'(cpu_ready), 0);
        fill(d);
        drained(r);
    endtask

    int watchdog = 0;
    always @(posedge clk) begin
        watchdog++;
        if (watchdog == 20000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", watchdog);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int b0, w0, s0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(cpu_ready == 1'b1, "R1", "cpu_ready", 32'(cpu_ready), 1);
        chk(cpu_done == 1'b0, "R1", "cpu_done", 32'(cpu_done), 0);
        chk(bus_valid == 1'b0, "R1", "bus_valid", 32'(bus_valid), 0);
        chk(wb_valid == 1'b0, "R1", "wb_valid", 32'(wb_valid), 0);
        chk(snp_supply == 1'b0, "R1", "snp_supply", 32'(snp_supply), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: read miss then fill -> unowned shared
        cur_req = "R2";
        rd_miss(A_ADR, 16'h1111, "R2");

        // R3: read hit, no bus
        cur_req = "R3"; b0 = n_bus;
        exp_cpu(16'h1111, "R3");
        access(1'b0, A_ADR, '0);
        chk(n_bus == b0, "R3", "bus requests on hit", 32'(n_bus - b0), 0);
        drained("R3");

        // R8: snooped read on unowned shared -> no supply, still valid
        cur_req = "R8"; s0 = n_sup; b0 = n_bus;
        snoop(C_RD, A_ADR);
        chk(n_sup == s0, "R8", "supply count", 32'(n_sup - s0), 0);
        exp_cpu(16'h1111, "R8");
        access(1'b0, A_ADR, '0);
        chk(n_bus == b0, "R8", "line still valid (no bus)", 32'(n_bus - b0), 0);

        // R4: write to unowned shared -> invalidate broadcast
        cur_req = "R4";
        exp_bus(C_KL, A_ADR, "R4");
        exp_cpu(16'h2222, "R4");
        access(1'b1, A_ADR, 16'h2222);
        drained("R4");

        // R5: write to owned exclusive -> silent
        cur_req = "R5"; b0 = n_bus;
        exp_cpu(16'h3333, "R5");
        access(1'b1, A_ADR, 16'h3333);
        chk(n_bus == b0, "R5", "bus requests on exclusive write", 32'(n_bus - b0), 0);
        drained("R5");

        // R7: snooped read on owner -> supply, then owned shared
        cur_req = "R7";
        exp_sup(16'h3333, "R7");
        snoop(C_RD, A_ADR);
        exp_bus(C_KL, A_ADR, "R7");
        exp_cpu(16'h4444, "R7");
        access(1'b1, A_ADR, 16'h4444);
        drained("R7");

        // R9: snooped read-exclusive on owner -> supply, invalid
        cur_req = "R9"; w0 = n_wb;
        exp_sup(16'h4444, "R9");
        snoop(C_RX, A_ADR);
        rd_miss(A_ADR, 16'h5555, "R9");
        chk(n_wb == w0, "R9", "write-back of invalid line", 32'(n_wb - w0), 0);
        // R9: snooped invalidate on unowned shared
        snoop(C_KL, A_ADR);
        rd_miss(A_ADR, 16'h6666, "R9");

        // R6 / R10: write miss, unowned shared victim dropped silently
        cur_req = "R6"; w0 = n_wb;
        exp_bus(C_RX, B_ADR, "R6");
        exp_cpu(16'hAAAA, "R6");
        access(1'b1, B_ADR, 16'hAAAA);
        fill(16'h0BAD);
        chk(n_wb == w0, "R10", "write-back of unowned victim", 32'(n_wb - w0), 0);
        b0 = n_bus;
        exp_cpu(16'hAAAA, "R6");
        access(1'b0, B_ADR, '0);
        chk(n_bus == b0, "R6", "owned line hit after write miss", 32'(n_bus - b0), 0);
        drained("R6");

        // R10: owned victim written back with the miss request
        cur_req = "R10";
        exp_wb(B_ADR, 16'hAAAA, "R10");
        rd_miss(A_ADR, 16'h7777, "R10");

        // R11: read-broadcast capture disabled
        cur_req = "R11";
        snoop(C_KL, A_ADR);
        rd_bcast_en = 1'b0;
        snoop_data(A_ADR, 16'h8888);
        rd_miss(A_ADR, 16'h9999, "R11");
        // R11: enabled, matching invalid line captures
        snoop(C_KL, A_ADR);
        rd_bcast_en = 1'b1;
        snoop_data(A_ADR, 16'hCCCC);
        b0 = n_bus;
        exp_cpu(16'hCCCC, "R11");
        access(1'b0, A_ADR, '0);
        chk(n_bus == b0, "R11", "captured line hit", 32'(n_bus - b0), 0);
        // R11: tag mismatch, no capture
        snoop_data(C_ADR, 16'h5A5A);
        rd_miss(C_ADR, 16'h1234, "R11");
        rd_bcast_en = 1'b0;

        // R9: read-exclusive on unowned shared -> invalid, no supply
        cur_req = "R9"; s0 = n_sup;
        snoop(C_RX, C_ADR);
        chk(n_sup == s0, "R9", "supply from unowned line", 32'(n_sup - s0), 0);
        rd_miss(C_ADR, 16'h4321, "R9");

        repeat (4) @(negedge clk);
        drained("R1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule